// File: doc/BRIEF.md
# Palette RAM Paired-Byte Writer

This block holds the 64-byte colour palette of a video display processor. It sits behind the processor's byte-wide data port. A command decoder outside the block provides the current control code and can load the port address. A data-port byte goes to palette RAM only when that control code selects palette writes. With any other code, the byte leaves the block on a video RAM write strobe at the current port address.

Palette entries are 16-bit slots, and each one is written as a pair of bytes. A byte sent to an even address waits in a holding latch, and the palette does not change. The next byte, sent to an odd address, writes the held byte and its own low nibble into the entry in one clock edge. So the renderer, reading through a separate combinational port, never sees half of an update. After every data-port write the port address moves forward by one, whatever the target.

Top module: `pal_byte_writer`

## Requirements
- R1: After reset `addr_o` is 0, `vram_we_o` is low, and every palette entry reads 0 on `rd_color_o`.
- R2: A write with `ctrl_code_i` other than 3 asserts `vram_we_o` in the same cycle, with `vram_addr_o` equal to the current address and `vram_data_o` equal to the byte. The palette and the holding latch are unchanged. A write with code 3 never asserts `vram_we_o`.
- R3: A palette write to an even address (bit 0 clear) only loads the holding latch. Every palette entry reads the same as before.
- R4: A palette write to an odd address stores the latch into the even byte and the incoming byte into the odd byte of the same entry, both at the same clock edge.
- R5: The odd byte keeps only bits 3:0 of the incoming data. Bits 7:4 are stored as zero.
- R6: Each data-port write increments the 14-bit address by one after the write, for either target. 0x3FFF wraps to 0x0000.
- R7: Palette byte address = port address bits 5:0, so higher addresses alias into the 64 bytes. Entry index = address bits 5:1.
- R8: An odd palette write with no even write before it commits whatever the latch holds: 0 after reset, otherwise the last even byte.
- R9: A pulse on `addr_load_i` sets the address to `addr_val_i` at the next edge. A load takes priority over the increment.
- R10: `rd_color_o` for index `rd_idx_i` is {odd byte[3:0], even byte[7:0]}, and it is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctrl_code_i | input | 2 | Current control code; 3 selects palette writes |
| addr_load_i | input | 1 | Load the port address |
| addr_val_i | input | 14 | Address value to load |
| wr_en_i | input | 1 | Data-port write strobe |
| wr_data_i | input | 8 | Data-port byte |
| addr_o | output | 14 | Current port address |
| vram_we_o | output | 1 | Video RAM write strobe |
| vram_addr_o | output | 14 | Video RAM write address |
| vram_data_o | output | 8 | Video RAM write byte |
| rd_idx_i | input | 5 | Renderer entry index |
| rd_color_o | output | 12 | Colour word of the selected entry |

## Verification
Four kinds of pair are written.

- **Even byte then odd byte.** The bench checks that the entry stays unchanged after the even byte and then takes the whole 12-bit value. This separates the deferred commit from a write that happens at once.
- **Odd byte with no even byte before it.** This is done once straight after reset and once after an intervening video RAM write. It shows whether the latch holds its stale value and whether video RAM traffic disturbs it.
- **Odd byte with bits 7:4 set.** This exposes a missing nibble mask.
- **Pairs at aliased and top-of-range addresses.** These test the 6-bit palette wrap, the entry index and the 14-bit address wrap.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned CODE_W = 2;

  typedef enum logic [CODE_W-1:0] {
    CODE_VRAM_RD = 2'd0,
    CODE_VRAM_WR = 2'd1,
    CODE_REG_WR  = 2'd2,
    CODE_PAL_WR  = 2'd3
  } ctrl_code_e;
endpackage

// File: rtl/pal_addr_ctr.sv
module pal_addr_ctr #(
  parameter int unsigned ADDR_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      addr_q <= '0;
    else if (load_i)  addr_q <= load_val_i;
    else if (step_i)  addr_q <= addr_q + 1'b1;
  end

  assign addr_o = addr_q;

  assert_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> (addr_q == $past(addr_q) + 1'b1));

  assert_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (addr_q == $past(load_val_i)));
endmodule

// File: rtl/pal_store.sv
module pal_store #(
  parameter int unsigned PAL_BYTES = 64,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned NIB_W     = 4,
  localparam int unsigned AW       = $clog2(PAL_BYTES)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              we_i,
  input  logic [AW-1:0]                     addr_i,
  input  logic [DATA_W-1:0]                 data_i,
  output logic [PAL_BYTES-1:0][DATA_W-1:0]  mem_o
);
  logic [PAL_BYTES-1:0][DATA_W-1:0] mem_q;
  logic [DATA_W-1:0]                latch_q;
  logic [AW-1:0]                    even_addr;
  logic [DATA_W-1:0]                odd_byte;

  assign even_addr = {addr_i[AW-1:1], 1'b0};
  assign odd_byte  = {{(DATA_W-NIB_W){1'b0}}, data_i[NIB_W-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= '0;
      mem_q   <= '0;
    end else if (we_i) begin
      if (!addr_i[0]) begin
        latch_q <= data_i;
      end else begin
        mem_q[even_addr] <= latch_q;
        mem_q[addr_i]    <= odd_byte;
      end
    end
  end

  assign mem_o = mem_q;

  assert_even_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !addr_i[0]) |=> (mem_q == $past(mem_q)));

  assert_pair_commit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i[0]) |=> (mem_q[$past(even_addr)] == $past(latch_q)));

  assert_odd_nibble_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i[0]) |=>
      (mem_q[$past(addr_i)][DATA_W-1:NIB_W] == '0 &&
       mem_q[$past(addr_i)][NIB_W-1:0] == $past(data_i[NIB_W-1:0])));
endmodule

// File: rtl/pal_read_port.sv
module pal_read_port #(
  parameter int unsigned PAL_BYTES = 64,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned NIB_W     = 4,
  localparam int unsigned ENTRIES  = PAL_BYTES / 2,
  localparam int unsigned IDX_W    = $clog2(ENTRIES),
  localparam int unsigned COL_W    = DATA_W + NIB_W
) (
  input  logic [PAL_BYTES-1:0][DATA_W-1:0] mem_i,
  input  logic [IDX_W-1:0]                 idx_i,
  output logic [COL_W-1:0]                 color_o
);
  logic [ENTRIES-1:0][COL_W-1:0] colors;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    assign colors[e] = {mem_i[2*e+1][NIB_W-1:0], mem_i[2*e]};
  end

  assign color_o = colors[idx_i];
endmodule

// File: rtl/pal_byte_writer.sv
module pal_byte_writer #(
  parameter int unsigned ADDR_W    = 14,
  parameter int unsigned PAL_BYTES = 64,
  parameter int unsigned NIB_W     = 4,
  localparam int unsigned DATA_W   = pal_pkg::DATA_W,
  localparam int unsigned CODE_W   = pal_pkg::CODE_W,
  localparam int unsigned PAL_AW   = $clog2(PAL_BYTES),
  localparam int unsigned IDX_W    = $clog2(PAL_BYTES / 2),
  localparam int unsigned COL_W    = DATA_W + NIB_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] ctrl_code_i,
  input  logic              addr_load_i,
  input  logic [ADDR_W-1:0] addr_val_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              vram_we_o,
  output logic [ADDR_W-1:0] vram_addr_o,
  output logic [DATA_W-1:0] vram_data_o,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [COL_W-1:0]  rd_color_o
);
  import pal_pkg::*;

  logic                             pal_we;
  logic [ADDR_W-1:0]                addr_q;
  logic [PAL_BYTES-1:0][DATA_W-1:0] pal_mem;

  assign pal_we      = wr_en_i && (ctrl_code_e'(ctrl_code_i) == CODE_PAL_WR);
  assign vram_we_o   = wr_en_i && !pal_we;
  assign vram_addr_o = addr_q;
  assign vram_data_o = wr_data_i;
  assign addr_o      = addr_q;

  pal_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (addr_load_i),
    .load_val_i (addr_val_i),
    .step_i     (wr_en_i),
    .addr_o     (addr_q)
  );

  pal_store #(.PAL_BYTES(PAL_BYTES), .DATA_W(DATA_W), .NIB_W(NIB_W)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (pal_we),
    .addr_i (addr_q[PAL_AW-1:0]),
    .data_i (wr_data_i),
    .mem_o  (pal_mem)
  );

  pal_read_port #(.PAL_BYTES(PAL_BYTES), .DATA_W(DATA_W), .NIB_W(NIB_W)) u_rd (
    .mem_i   (pal_mem),
    .idx_i   (rd_idx_i),
    .color_o (rd_color_o)
  );

  assert_one_target_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> ($countones({vram_we_o, pal_we}) == 1));

  assert_vram_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vram_we_o |=> (pal_mem == $past(pal_mem)));
endmodule

// File: tb/pal_byte_writer_tb_top.sv
module pal_byte_writer_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  ctrl_code = 2'd0;
  logic        addr_load = 1'b0;
  logic [13:0] addr_val = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [13:0] addr_o;
  logic        vram_we;
  logic [13:0] vram_addr;
  logic [7:0]  vram_data;
  logic [4:0]  rd_idx = '0;
  logic [11:0] rd_color;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic        cap_we;
  logic [13:0] cap_addr;
  logic [7:0]  cap_data;

  always #2.5 clk = ~clk;

  pal_byte_writer dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .ctrl_code_i(ctrl_code),
    .addr_load_i(addr_load), .addr_val_i(addr_val),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .addr_o(addr_o),
    .vram_we_o(vram_we), .vram_addr_o(vram_addr), .vram_data_o(vram_data),
    .rd_idx_i(rd_idx), .rd_color_o(rd_color)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic load_addr(input logic [13:0] a);
    @(negedge clk);
    addr_load = 1'b1; addr_val = a;
    @(negedge clk);
    addr_load = 1'b0;
  endtask

  // Drives one write; captures the combinational video RAM outputs mid-cycle.
  task automatic wr(input logic [1:0] code, input logic [7:0] d);
    @(negedge clk);
    ctrl_code = code; wr_en = 1'b1; wr_data = d;
    #1;
    cap_we = vram_we; cap_addr = vram_addr; cap_data = vram_data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic color_at(input logic [4:0] idx, output logic [11:0] c);
    rd_idx = idx;
    #1;
    c = rd_color;
  endtask

  task automatic t_reset;
    logic [11:0] c;
    chk("R1 addr", 32'(addr_o), 32'h0);
    chk("R1 vram_we", 32'(vram_we), 32'h0);
    for (int i = 0; i < 32; i++) begin
      color_at(5'(i), c);
      chk("R1 entry", 32'(c), 32'h0);
    end
  endtask

  task automatic t_first_odd;
    logic [11:0] c;
    load_addr(14'h0001);
    chk("R9 load", 32'(addr_o), 32'h1);
    wr(2'd3, 8'hFF);
    chk("R2 no vram on palette write", 32'(cap_we), 32'h0);
    color_at(5'd0, c);
    chk("R8 reset latch commit", 32'(c), 32'hF00);
  endtask

  task automatic t_pair;
    logic [11:0] c;
    load_addr(14'h0004);
    wr(2'd3, 8'hA5);
    color_at(5'd2, c);
    chk("R3 even write holds entry", 32'(c), 32'h0);
    chk("R6 step after even", 32'(addr_o), 32'h5);
    wr(2'd3, 8'hF7);
    color_at(5'd2, c);
    chk("R4 R5 R10 pair commit", 32'(c), 32'h7A5);
    chk("R6 step after odd", 32'(addr_o), 32'h6);
  endtask

  task automatic t_vram;
    logic [11:0] c;
    load_addr(14'h1234);
    wr(2'd1, 8'h5C);
    chk("R2 vram_we", 32'(cap_we), 32'h1);
    chk("R2 vram_addr", 32'(cap_addr), 32'h1234);
    chk("R2 vram_data", 32'(cap_data), 32'h5C);
    chk("R6 step after vram", 32'(addr_o), 32'h1235);
    wr(2'd0, 8'h99);
    chk("R2 vram_we code0", 32'(cap_we), 32'h1);
    color_at(5'd26, c);
    chk("R2 palette untouched", 32'(c), 32'h0);
  endtask

  task automatic t_stale;
    logic [11:0] c;
    load_addr(14'h000B);
    wr(2'd3, 8'h3C);
    color_at(5'd5, c);
    chk("R8 stale latch commit", 32'(c), 32'hCA5);
  endtask

  task automatic t_alias;
    logic [11:0] c;
    load_addr(14'h0046);
    wr(2'd3, 8'h77);
    wr(2'd3, 8'h08);
    color_at(5'd3, c);
    chk("R7 alias entry", 32'(c), 32'h877);
  endtask

  task automatic t_wrap;
    logic [11:0] c;
    load_addr(14'h3FFE);
    wr(2'd3, 8'h11);
    wr(2'd3, 8'h92);
    color_at(5'd31, c);
    chk("R7 top entry", 32'(c), 32'h211);
    chk("R6 wrap", 32'(addr_o), 32'h0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_odd();
    t_pair();
    t_vram();
    t_stale();
    t_alias();
    t_wrap();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end
endmodule